// File: doc/BRIEF.md
# Descriptor-Chained Memory-to-Stream DMA Engine

This engine moves bytes from memory to a streaming consumer by following a chain of four-word descriptors. Each descriptor names a buffer by its start address and an exclusive end address. It also carries flags for end of list, end of packet and interrupt request, plus a 16-bit metadata tag. The engine streams the buffer one 32-bit word per beat and writes the descriptor back when it is done. It then follows the next pointer, or it stops at the end of the list and sets the disable bit in the channel's context word.

Software, through logic outside this block, hands the engine a descriptor address together with a command code. A command that loads and starts sets the channel running. A later continue pulse can resume a chain that stopped at end of list, once software has cleared that descriptor's end-of-list flag. The metadata tag is announced to the consumer once at the head of every packet.

Top module: `dma_chain_out`

## Requirements
- R1: A descriptor is four little-endian words at a word-aligned base: +0 next pointer, +4 buffer start, +8 flags, +12 buffer end (exclusive). In the flags word, bit 0 is end of list, bit 3 is end of packet, bit 4 is interrupt request and bits 31:16 are metadata. Every memory request uses a word-aligned address.
- R2: When `enable_i` is high, a `cmd_valid_i` pulse with bit 6 or bit 8 of `cmd_i` set fetches the descriptor at `desc_addr_i`. If bit 5 is also set, the channel enters the running state and starts streaming. Without bit 5, nothing is streamed and the engine returns to idle.
- R3: Buffer bytes are streamed in address order, little-endian, one word per beat. `st_bytes_o` is 4 on every beat except the last beat of a descriptor, which carries the remaining 1 to 4 bytes. The total number of bytes equals end minus start.
- R4: `st_last_o` is high only on the final beat of a descriptor whose end-of-packet flag is set.
- R5: While `st_ready_i` is low, a presented beat holds its data, byte count and last flag unchanged.
- R6: `md_valid_o` pulses for one cycle with the descriptor's metadata before the first beat after a start or a resume, and before the first beat of any descriptor that follows an end-of-packet descriptor. It does not pulse for a descriptor that follows one without end of packet, and a beat is never presented in the cycle after the pulse.
- R7: `irq_done_o` pulses for one cycle when a descriptor with its interrupt flag completes, and never otherwise.
- R8: A completing descriptor's four words are written back to its own location.
- R9: After an end-of-list descriptor completes, the engine reads the word at `ctx_addr_i`+4, rewrites it with bit 15 set, raises `eol_o` and goes idle. Without end of list, it fetches the descriptor at the next pointer.
- R10: A descriptor whose end is not above its start streams no beats but still completes: metadata, write-back, interrupt and end-of-list handling all happen.
- R11: `cont_i` is honoured only while the channel is running, `stop_i` is low and the held descriptor has end of list set. The engine then re-reads that descriptor. If end of list is now clear, it clears `eol_o` and resumes at the descriptor's next pointer. Otherwise it stays idle. Asserting `stop_i` takes the channel out of the running state.
- R12: Streaming is split into bursts of at most `BURST_BYTES` bytes. Between bursts the descriptor is re-read and streaming continues, with no last flag and no metadata at the boundary.
- R13: With `enable_i` low, the engine is forced idle: no beat is presented, `eol_o` is cleared and the channel leaves the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Channel enable; low forces idle |
| stop_i | input | 1 | Stop request; clears the running state |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 10 | Command code (bits 6/8 load, bit 5 start) |
| desc_addr_i | input | AW | Descriptor address used by a command |
| ctx_addr_i | input | AW | Context base address |
| cont_i | input | 1 | Continue pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | AW | Memory byte address (word aligned) |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory accepts request; read data valid this cycle |
| mem_rdata_i | input | 32 | Memory read data |
| st_valid_o | output | 1 | Stream beat valid |
| st_ready_i | input | 1 | Stream consumer ready |
| st_data_o | output | 32 | Stream data, little-endian |
| st_bytes_o | output | 3 | Valid bytes in beat (1..4) |
| st_last_o | output | 1 | End of packet |
| md_valid_o | output | 1 | Metadata strobe |
| md_o | output | 16 | Metadata value |
| irq_done_o | output | 1 | Descriptor-complete interrupt event |
| eol_o | output | 1 | Channel reached end of list |
| busy_o | output | 1 | Engine not idle |

## Verification
The bench targets unaligned buffer ends. An engine that got the final-beat byte count wrong would shift the weighted byte checksum or the byte total. Zero-length descriptors are run with end of packet and interrupt set: a design that skipped completion for them would lose the write-back, the interrupt or the end-of-list stop. A three-descriptor chain mixes packet and non-packet descriptors, which exposes metadata sent once per descriptor instead of once per packet. Continue is exercised in its honoured, still-at-end and stopped forms, along with a transfer longer than one burst and a disable in the middle of a transfer.

// File: rtl/dma_out_pkg.sv
package dma_out_pkg;
  localparam int DW = 32;

  localparam int FL_EOL     = 0;
  localparam int FL_EOP     = 3;
  localparam int FL_INTR    = 4;
  localparam int FL_MD_LSB  = 16;
  localparam int CTX_DIS    = 15;
  localparam int CMD_START  = 5;
  localparam logic [9:0] CMD_LOAD_MASK = 10'h140;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_META, S_XFER, S_WBACK, S_CTX_RD, S_CTX_WR
  } state_e;

  typedef enum logic [2:0] {
    LK_PEEK, LK_START, LK_CONT, LK_NEXT, LK_RELOAD
  } load_e;
endpackage

// File: rtl/dma_beat_calc.sv
module dma_beat_calc #(
  parameter int AW          = 32,
  parameter int BURST_BYTES = 2048,
  localparam int BCW        = $clog2(BURST_BYTES + 1)
) (
  input  logic [AW-1:0]  ptr_i,
  input  logic [AW-1:0]  end_i,
  input  logic [BCW-1:0] bcnt_i,
  output logic           empty_o,
  output logic [2:0]     bytes_o,
  output logic           final_o,
  output logic           burst_hit_o
);
  logic [AW-1:0] rem;
  logic [BCW:0]  bsum;

  always_comb begin
    rem         = (end_i > ptr_i) ? end_i - ptr_i : '0;
    empty_o     = (rem == '0);
    bytes_o     = (rem >= AW'(4)) ? 3'd4 : rem[2:0];
    final_o     = (rem <= AW'(4));
    bsum        = (BCW+1)'(bcnt_i) + (BCW+1)'(bytes_o);
    burst_hit_o = (bsum >= (BCW+1)'(BURST_BYTES)) && !final_o;
  end
endmodule

// File: rtl/dma_stream_reg.sv
module dma_stream_reg #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic [2:0]    bytes_i,
  input  logic          last_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic [2:0]    bytes_o,
  output logic          last_o,
  output logic          free_o
);
  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      bytes_o <= '0;
      last_o  <= 1'b0;
    end else if (flush_i) begin
      valid_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
      bytes_o <= bytes_i;
      last_o  <= last_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_STREAM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !flush_i) |=> (valid_o && $stable(data_o) && $stable(bytes_o) && $stable(last_o))); // R5
  AST_LOAD_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> free_o); // R5
endmodule

// File: rtl/dma_chain_out.sv
module dma_chain_out
  import dma_out_pkg::*;
#(
  parameter int AW          = 32,
  parameter int BURST_BYTES = 2048,
  localparam int BCW        = $clog2(BURST_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          stop_i,
  input  logic          cmd_valid_i,
  input  logic [9:0]    cmd_i,
  input  logic [AW-1:0] desc_addr_i,
  input  logic [AW-1:0] ctx_addr_i,
  input  logic          cont_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          st_valid_o,
  input  logic          st_ready_i,
  output logic [31:0]   st_data_o,
  output logic [2:0]    st_bytes_o,
  output logic          st_last_o,
  output logic          md_valid_o,
  output logic [15:0]   md_o,
  output logic          irq_done_o,
  output logic          eol_o,
  output logic          busy_o
);
  state_e         state_q;
  load_e          kind_q;
  logic [1:0]     idx_q;
  logic [AW-1:0]  cur_q, ptr_q;
  logic [DW-1:0]  desc_q [4];
  logic [DW-1:0]  ctx_q;
  logic [BCW-1:0] bcnt_q;
  logic           run_q, eol_q, md_pend_q, irq_q;

  logic       empty, fin, burst_hit, strm_free, mem_fire, strm_load;
  logic [2:0] beat_bytes;
  logic       cmd_go, cont_ok;

  dma_beat_calc #(.AW(AW), .BURST_BYTES(BURST_BYTES)) u_calc (
    .ptr_i       (ptr_q),
    .end_i       (desc_q[3][AW-1:0]),
    .bcnt_i      (bcnt_q),
    .empty_o     (empty),
    .bytes_o     (beat_bytes),
    .final_o     (fin),
    .burst_hit_o (burst_hit)
  );

  assign mem_fire  = mem_req_o && mem_ack_i;
  assign strm_load = (state_q == S_XFER) && mem_fire;

  dma_stream_reg #(.DW(DW)) u_strm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!enable_i),
    .load_i  (strm_load),
    .data_i  (mem_rdata_i),
    .bytes_i (beat_bytes),
    .last_i  (fin && desc_q[2][FL_EOP]),
    .ready_i (st_ready_i),
    .valid_o (st_valid_o),
    .data_o  (st_data_o),
    .bytes_o (st_bytes_o),
    .last_o  (st_last_o),
    .free_o  (strm_free)
  );

  assign cmd_go  = cmd_valid_i && |(cmd_i & CMD_LOAD_MASK);
  assign cont_ok = cont_i && !stop_i && run_q && desc_q[2][FL_EOL];

  assign md_valid_o = (state_q == S_META) && md_pend_q && !st_valid_o;
  assign md_o       = desc_q[2][31:FL_MD_LSB];
  assign irq_done_o = irq_q;
  assign eol_o      = eol_q;
  assign busy_o     = (state_q != S_IDLE);

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (state_q)
      S_LOAD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = cur_q + AW'({idx_q, 2'b00});
      end
      S_XFER: begin
        mem_req_o  = !empty && strm_free;
        mem_addr_o = {ptr_q[AW-1:2], 2'b00};
      end
      S_WBACK: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = cur_q + AW'({idx_q, 2'b00});
        mem_wdata_o = desc_q[idx_q];
      end
      S_CTX_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ctx_addr_i + AW'(4);
      end
      S_CTX_WR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ctx_addr_i + AW'(4);
        mem_wdata_o = ctx_q | (DW'(1) << CTX_DIS);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      kind_q    <= LK_PEEK;
      idx_q     <= '0;
      cur_q     <= '0;
      ptr_q     <= '0;
      ctx_q     <= '0;
      bcnt_q    <= '0;
      run_q     <= 1'b0;
      eol_q     <= 1'b0;
      md_pend_q <= 1'b0;
      irq_q     <= 1'b0;
      for (int i = 0; i < 4; i++) desc_q[i] <= '0;
    end else if (!enable_i) begin
      state_q   <= S_IDLE;
      run_q     <= 1'b0;
      eol_q     <= 1'b0;
      md_pend_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (stop_i) run_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          idx_q <= '0;
          if (cmd_go) begin
            cur_q   <= desc_addr_i;
            kind_q  <= cmd_i[CMD_START] ? LK_START : LK_PEEK;
            state_q <= S_LOAD;
          end else if (cont_ok) begin
            kind_q  <= LK_CONT;
            state_q <= S_LOAD;
          end
        end
        S_LOAD: if (mem_fire) begin
          desc_q[idx_q] <= mem_rdata_i;
          idx_q         <= idx_q + 2'd1;
          if (idx_q == 2'd3) begin
            case (kind_q)
              LK_PEEK: begin
                ptr_q   <= desc_q[1][AW-1:0];
                state_q <= S_IDLE;
              end
              LK_START: begin
                ptr_q     <= desc_q[1][AW-1:0];
                bcnt_q    <= '0;
                run_q     <= 1'b1;
                eol_q     <= 1'b0;
                md_pend_q <= 1'b1;
                state_q   <= S_META;
              end
              LK_NEXT: begin
                ptr_q   <= desc_q[1][AW-1:0];
                bcnt_q  <= '0;
                state_q <= S_META;
              end
              LK_RELOAD: begin
                bcnt_q  <= '0;
                state_q <= S_XFER;
              end
              LK_CONT: begin
                if (!desc_q[2][FL_EOL] && eol_q) begin
                  eol_q     <= 1'b0;
                  md_pend_q <= 1'b1;
                  cur_q     <= desc_q[0][AW-1:0];
                  kind_q    <= LK_NEXT;
                  state_q   <= S_LOAD;
                end else begin
                  state_q <= S_IDLE;
                end
              end
              default: state_q <= S_IDLE;
            endcase
          end
        end
        S_META: if (!st_valid_o) begin
          md_pend_q <= 1'b0;
          state_q   <= S_XFER;
        end
        S_XFER: begin
          if (empty) begin
            irq_q   <= desc_q[2][FL_INTR];
            idx_q   <= '0;
            state_q <= S_WBACK;
          end else if (mem_fire) begin
            ptr_q  <= ptr_q + AW'(beat_bytes);
            bcnt_q <= bcnt_q + BCW'(beat_bytes);
            if (burst_hit) begin
              idx_q   <= '0;
              kind_q  <= LK_RELOAD;
              state_q <= S_LOAD;
            end
          end
        end
        S_WBACK: if (mem_fire) begin
          idx_q <= idx_q + 2'd1;
          if (idx_q == 2'd3) begin
            if (desc_q[2][FL_EOP]) md_pend_q <= 1'b1;
            if (desc_q[2][FL_EOL]) begin
              state_q <= S_CTX_RD;
            end else begin
              cur_q   <= desc_q[0][AW-1:0];
              kind_q  <= LK_NEXT;
              state_q <= S_LOAD;
            end
          end
        end
        S_CTX_RD: if (mem_fire) begin
          ctx_q   <= mem_rdata_i;
          state_q <= S_CTX_WR;
        end
        S_CTX_WR: if (mem_fire) begin
          eol_q   <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_ALIGNED_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00)); // R1
  AST_MD_BEFORE_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    md_valid_o |=> !st_valid_o); // R6
  AST_IRQ_AT_WBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_done_o |-> (mem_req_o && mem_we_o)); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_done_o |=> !irq_done_o); // R7
  AST_EOL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eol_o) |-> !busy_o); // R9
  AST_DISABLE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!busy_o && !st_valid_o && !eol_o)); // R13
endmodule

// File: tb/dma_chain_out_tb.sv
`timescale 1ns/1ps
module dma_chain_out_tb_top;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          enable_i = 1'b0, stop_i = 1'b0, cmd_valid_i = 1'b0, cont_i = 1'b0;
  logic [9:0]    cmd_i = '0;
  logic [AW-1:0] desc_addr_i = '0, ctx_addr_i = 32'h80;
  logic          mem_req_o, mem_we_o, mem_ack_i, st_valid_o, st_ready_i, st_last_o;
  logic          md_valid_o, irq_done_o, eol_o, busy_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0]   mem_wdata_o, mem_rdata_i, st_data_o;
  logic [2:0]    st_bytes_o;
  logic [15:0]   md_o;

  logic [31:0] mem [0:4095];
  assign mem_rdata_i = mem[mem_addr_o[13:2]];

  dma_chain_out #(.AW(AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable_i), .stop_i(stop_i),
    .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i), .desc_addr_i(desc_addr_i),
    .ctx_addr_i(ctx_addr_i), .cont_i(cont_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .st_valid_o(st_valid_o), .st_ready_i(st_ready_i), .st_data_o(st_data_o),
    .st_bytes_o(st_bytes_o), .st_last_o(st_last_o),
    .md_valid_o(md_valid_o), .md_o(md_o), .irq_done_o(irq_done_o),
    .eol_o(eol_o), .busy_o(busy_o)
  );

  int checks = 0, errors = 0;
  int rdy_mode = 0, ack_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  int beats, nbytes, lasts, last_bytes, md_cnt, irq_cnt, wr_cnt, mon_pos, exp_pos;
  logic [15:0] md_last;
  longint mon_sum, exp_sum;

  // vectors: len, eop, intr, stall (0 none, 1 ready+ack random)
  localparam int VEC [0:5][0:3] = '{
    '{8, 1, 1, 0}, '{5, 1, 0, 0}, '{3, 0, 0, 0},
    '{1, 0, 1, 1}, '{0, 1, 1, 0}, '{13, 1, 0, 1}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    st_ready_i = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;
    mem_ack_i  = (ack_mode == 0) ? 1'b1 : lfsr[5];
    if (st_valid_o && st_ready_i) begin
      beats++;
      for (int b = 0; b < 4; b++)
        if (b < int'(st_bytes_o)) begin
          mon_pos++;
          mon_sum += longint'(st_data_o[8*b +: 8]) * mon_pos;
          nbytes++;
        end
      if (st_last_o) begin
        lasts++;
        last_bytes = int'(st_bytes_o);
      end
    end
    if (md_valid_o) begin
      md_cnt++;
      md_last = md_o;
    end
    if (irq_done_o) irq_cnt++;
    if (mem_req_o && mem_we_o && mem_ack_i) begin
      mem[mem_addr_o[13:2]] = mem_wdata_o;
      wr_cnt++;
    end
  end

  task automatic clear_mon();
    beats = 0; nbytes = 0; lasts = 0; last_bytes = 0; md_cnt = 0; irq_cnt = 0;
    wr_cnt = 0; mon_pos = 0; exp_pos = 0; mon_sum = 0; exp_sum = 0; md_last = '0;
  endtask

  task automatic put_desc(input int a, input int nxt, input int st, input int len,
                          input bit eop, input bit intr, input bit eol, input logic [15:0] md);
    mem[a/4]     = nxt;
    mem[a/4 + 1] = st;
    mem[a/4 + 2] = {md, 11'd0, intr, eop, 2'b00, eol};
    mem[a/4 + 3] = st + len;
    for (int k = 0; k < len; k++) mem[(st+k)/4][8*((st+k)%4) +: 8] = bval(st + k);
  endtask

  task automatic expect_bytes(input int st, input int len);
    for (int k = 0; k < len; k++) begin
      exp_pos++;
      exp_sum += longint'(bval(st + k)) * exp_pos;
    end
  endtask

  task automatic pulse_cmd(input int a, input logic [9:0] c);
    @(negedge clk);
    desc_addr_i = a; cmd_i = c; cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic pulse_cont();
    @(negedge clk); cont_i = 1'b1;
    @(negedge clk); cont_i = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    repeat (3) @(negedge clk);
    while (busy_o && n < 20000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    clear_mon();
    repeat (3) @(negedge clk);
    chk(!busy_o && !eol_o && !st_valid_o, "R13 reset idle", busy_o, 0);
    chk(!mem_req_o && !md_valid_o && !irq_done_o, "R13 reset quiet", mem_req_o, 0);
    rst_n = 1'b1;
    enable_i = 1'b1;

    // table of single end-of-list descriptors
    for (int v = 0; v < 6; v++) begin
      int len, eop, intr, stall;
      len = VEC[v][0]; eop = VEC[v][1]; intr = VEC[v][2]; stall = VEC[v][3];
      rdy_mode = stall; ack_mode = stall;
      mem[32'h84/4] = 32'h11;
      put_desc(32'h100, 32'h0, 32'h1000, len, eop[0], intr[0], 1'b1, 16'(16'h100 + v));
      clear_mon();
      expect_bytes(32'h1000, len);
      pulse_cmd(32'h100, 10'h160);
      wait_idle();
      chk(nbytes == len, "R3 byte count", nbytes, len);
      chk(mon_sum == exp_sum, "R3 data order", mon_sum, exp_sum);
      chk(beats == (len + 3) / 4, "R3 beats", beats, (len + 3) / 4);
      chk(lasts == ((eop != 0 && len > 0) ? 1 : 0), "R4 last count", lasts, (eop != 0 && len > 0));
      if (eop != 0 && len > 0)
        chk(last_bytes == ((len % 4 == 0) ? 4 : len % 4), "R3 final beat bytes", last_bytes, (len % 4 == 0) ? 4 : len % 4);
      chk(irq_cnt == intr, "R7 irq", irq_cnt, intr);
      chk(md_cnt == 1 && md_last == 16'(16'h100 + v), "R6 metadata", md_last, 16'h100 + v);
      chk(wr_cnt == 5, "R8 write-back count", wr_cnt, 5);
      chk(mem[32'h84/4] == 32'h8011, "R9 context disable", mem[32'h84/4], 32'h8011);
      chk(eol_o, "R9 eol set", eol_o, 1);
      if (len == 0) chk(beats == 0 && wr_cnt == 5, "R10 zero length completes", beats, 0);
    end
    rdy_mode = 0; ack_mode = 0;

    // chain: non-eop, eop+intr, eop+eol
    put_desc(32'h100, 32'h120, 32'h1100, 6, 1'b0, 1'b0, 1'b0, 16'h1111);
    put_desc(32'h120, 32'h140, 32'h1200, 4, 1'b1, 1'b1, 1'b0, 16'h2222);
    put_desc(32'h140, 32'h0,   32'h1300, 9, 1'b1, 1'b0, 1'b1, 16'h5555);
    clear_mon();
    expect_bytes(32'h1100, 6); expect_bytes(32'h1200, 4); expect_bytes(32'h1300, 9);
    pulse_cmd(32'h100, 10'h160);
    wait_idle();
    chk(nbytes == 19 && mon_sum == exp_sum, "R9 chain follows next", nbytes, 19);
    chk(md_cnt == 2 && md_last == 16'h5555, "R6 metadata per packet", md_cnt, 2);
    chk(lasts == 2, "R4 chain last count", lasts, 2);
    chk(irq_cnt == 1, "R7 chain irq", irq_cnt, 1);
    chk(wr_cnt == 13, "R8 chain write-backs", wr_cnt, 13);

    // continue while end of list still set: no effect
    clear_mon();
    pulse_cont();
    wait_idle();
    chk(beats == 0 && eol_o, "R11 continue at eol", beats, 0);

    // continue after clearing end of list
    put_desc(32'h180, 32'h0, 32'h1400, 4, 1'b1, 1'b0, 1'b1, 16'h3333);
    mem[32'h140/4]     = 32'h180;
    mem[32'h140/4 + 2] = mem[32'h140/4 + 2] & ~32'h1;
    clear_mon();
    expect_bytes(32'h1400, 4);
    pulse_cont();
    wait_idle();
    chk(nbytes == 4 && mon_sum == exp_sum, "R11 resume streams next", nbytes, 4);
    chk(md_cnt == 1 && md_last == 16'h3333, "R11 resume metadata", md_last, 16'h3333);
    chk(eol_o && wr_cnt == 5, "R11 resume ends at eol", wr_cnt, 5);

    // stop takes the channel out of running: continue ignored
    mem[32'h180/4 + 2] = mem[32'h180/4 + 2] & ~32'h1;
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    clear_mon();
    pulse_cont();
    wait_idle();
    chk(beats == 0 && wr_cnt == 0 && eol_o, "R11 stopped ignores continue", beats, 0);

    // longer than one burst
    put_desc(32'h100, 32'h0, 32'h2000, 2052, 1'b1, 1'b0, 1'b1, 16'h4444);
    clear_mon();
    expect_bytes(32'h2000, 2052);
    pulse_cmd(32'h100, 10'h160);
    wait_idle();
    chk(nbytes == 2052 && mon_sum == exp_sum, "R12 burst split data", nbytes, 2052);
    chk(lasts == 1 && last_bytes == 4 && md_cnt == 1, "R12 no boundary last", lasts, 1);

    // disable in the middle of a stalled transfer
    put_desc(32'h100, 32'h0, 32'h1000, 64, 1'b1, 1'b0, 1'b1, 16'h6666);
    rdy_mode = 2;
    pulse_cmd(32'h100, 10'h160);
    repeat (20) @(negedge clk);
    chk(busy_o && st_valid_o, "R5 stalled beat pending", busy_o, 1);
    enable_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(!busy_o && !st_valid_o && !eol_o, "R13 disable forces idle", busy_o, 0);
    enable_i = 1'b1;
    rdy_mode = 0;

    // load without start: nothing streamed
    put_desc(32'h100, 32'h0, 32'h1000, 8, 1'b1, 1'b1, 1'b1, 16'h7777);
    clear_mon();
    pulse_cmd(32'h100, 10'h140);
    wait_idle();
    chk(beats == 0 && md_cnt == 0 && wr_cnt == 0 && !eol_o, "R2 load only", beats, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule